// File: doc/BRIEF.md
# Source Address Learning Table with Aging

This block keeps the station table of a small two-port Ethernet switch. Upstream logic extracts the addresses from each frame. At the end of every received frame it presents the source address, the ingress port and a flag that says whether the frame was free of errors and of legal length. The block learns the address into a hashed, direct-mapped table, or refreshes it there, and each entry records the address, the port it was last seen on and a short epoch stamp. The forwarding engine asks about a destination address on a separate lookup port. One cycle later it gets back a hit flag and the stored port. On a miss it floods the frame.

A free-running scanner walks the table one slot per cycle. It removes entries whose stamp has fallen two epochs behind the current epoch. A 2-bit control input sets the length of an epoch or stops aging altogether. A per-port enable vector can switch off learning on either port. Multicast and broadcast source addresses are never stored.

Top module: `mac_learn_table`

## Requirements
- R1: After reset the table holds no entries, and `lk_ack` and `lk_hit` are low.
- R2: A lookup sampled with `lk_req` high gives `lk_ack` high one cycle later. In that same cycle `lk_hit` is high exactly when the slot for `lk_mac` holds that address, and `lk_port` carries its stored port (0 on a miss). Without `lk_req`, both `lk_ack` and `lk_hit` are low one cycle later.
- R3: The slot index is the low IDX_W bits of a CRC-32 over the address. The CRC uses polynomial 0x04C11DB7, starts from all ones, takes address bit 47 first and down to bit 0, and applies no final inversion. A slot holds one entry, and learning a different address into an occupied slot replaces the old entry.
- R4: An update is applied only when `up_req` and `up_good` are both high. A frame flagged bad neither inserts nor refreshes an entry.
- R5: When `learn_en[p]` is 0, updates from port p are ignored. This covers new inserts and port moves of known addresses.
- R6: A source address whose group bit (address bit 40) is set is never learned.
- R7: An accepted update for an address already in the table rewrites its stamp with the current epoch and its port with `up_port`.
- R8: When a lookup and an update fall in the same cycle, the lookup answers from the table as it stood before that update.
- R9: `age_sel` sets the epoch length: 0 stops aging, 1 gives TICK_UNIT cycles, 2 gives 4×TICK_UNIT cycles and 3 gives 16×TICK_UNIT cycles. The 2-bit epoch counter advances by exactly one at the end of each epoch and holds while aging is off.
- R10: While aging is on, the scanner deletes an entry once (epoch − stamp) mod 4 is at least 2. While aging is off, no entry is deleted.
- R11: The scanner moves to the next slot every cycle, except in a cycle where an update writes the table. In that cycle it holds its position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| learn_en | input | PORTS | Per-port learning enable |
| age_sel | input | 2 | Epoch length select (0 = aging off) |
| lk_req | input | 1 | Lookup request |
| lk_mac | input | 48 | Destination address to look up |
| lk_ack | output | 1 | Lookup result valid, one cycle after the request |
| lk_hit | output | 1 | Address found in the table |
| lk_port | output | PORT_W | Port stored for the address found |
| up_req | input | 1 | End-of-frame learn request |
| up_mac | input | 48 | Source address of the frame |
| up_port | input | PORT_W | Ingress port of the frame |
| up_good | input | 1 | Frame was error-free and of legal length |

## Verification
The bench builds a pair of unicast addresses that share a slot. A table that kept both, or that kept the older one, would answer the evicted address with a stale hit. Bad frames, disabled ports and group-bit sources are sent through the update port and then looked up. A design that leaked any of them into the table would report a hit or a changed port. A lookup is issued in the same cycle as the learn of the same address, and it must miss. A write-first table would hit one cycle early. For aging, one entry is refreshed every 1000 cycles while a partner is left alone. Entries are also held across several epoch lengths and with aging switched off. An epoch timer with the wrong period, a wrong expiry threshold or a refresh that did not restamp would keep an old entry too long or drop a live one.

// File: rtl/mlt_pkg.sv
package mlt_pkg;

  localparam int          MAC_W      = 48;
  localparam int          STAMP_W    = 2;
  localparam int          GROUP_BIT  = 40;
  localparam int          EXPIRE_AGE = 2;
  localparam logic [31:0] CRC_POLY   = 32'h04C1_1DB7;

  typedef enum logic [1:0] {
    AGE_OFF = 2'd0,
    AGE_X1  = 2'd1,
    AGE_X4  = 2'd2,
    AGE_X16 = 2'd3
  } age_sel_e;

  typedef enum logic [1:0] {
    ACT_NONE    = 2'd0,
    ACT_INSERT  = 2'd1,
    ACT_REFRESH = 2'd2,
    ACT_REPLACE = 2'd3
  } learn_act_e;

  // Serial CRC-32, address bit 47 first, init all ones, no final inversion.
  function automatic logic [31:0] mac_crc(input logic [MAC_W-1:0] mac);
    logic [31:0] c;
    logic        fb;
    c = '1;
    for (int i = MAC_W - 1; i >= 0; i--) begin
      fb = c[31] ^ mac[i];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/mlt_rst_sync.sv
module mlt_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/mlt_hash.sv
module mlt_hash #(
  parameter int IDX_W = 10
) (
  input  logic [mlt_pkg::MAC_W-1:0] mac,
  output logic [IDX_W-1:0]          idx
);

  assign idx = IDX_W'(mlt_pkg::mac_crc(mac));

endmodule

// File: rtl/mlt_store.sv
module mlt_store #(
  parameter int IDX_W    = 10,
  parameter int PORT_W   = 1,
  parameter int RD_PORTS = 3
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic [RD_PORTS-1:0][IDX_W-1:0]                rd_idx,
  output logic [RD_PORTS-1:0]                           rd_vld,
  output logic [RD_PORTS-1:0][mlt_pkg::MAC_W-1:0]       rd_mac,
  output logic [RD_PORTS-1:0][PORT_W-1:0]               rd_port,
  output logic [RD_PORTS-1:0][mlt_pkg::STAMP_W-1:0]     rd_stamp,
  input  logic                                          wr_en,
  input  logic [IDX_W-1:0]                              wr_idx,
  input  logic [mlt_pkg::MAC_W-1:0]                     wr_mac,
  input  logic [PORT_W-1:0]                             wr_port,
  input  logic [mlt_pkg::STAMP_W-1:0]                   wr_stamp,
  input  logic                                          clr_en,
  input  logic [IDX_W-1:0]                              clr_idx
);

  localparam int DEPTH = 1 << IDX_W;

  logic [mlt_pkg::MAC_W-1:0]   mac_mem   [DEPTH];
  logic [PORT_W-1:0]           port_mem  [DEPTH];
  logic [mlt_pkg::STAMP_W-1:0] stamp_mem [DEPTH];
  logic [DEPTH-1:0]            vld_q;
  logic [DEPTH-1:0]            vld_d;

  // Occupancy flags: set on write, cleared by the scanner.
  always_comb begin
    vld_d = vld_q;
    if (clr_en) vld_d[clr_idx] = 1'b0;
    if (wr_en)  vld_d[wr_idx]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // Entry payload needs no reset: it is qualified by the flag.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mac_mem[wr_idx]   <= wr_mac;
      port_mem[wr_idx]  <= wr_port;
      stamp_mem[wr_idx] <= wr_stamp;
    end
  end

  for (genvar g = 0; g < RD_PORTS; g++) begin : g_rd
    assign rd_vld[g]   = vld_q[rd_idx[g]];
    assign rd_mac[g]   = mac_mem[rd_idx[g]];
    assign rd_port[g]  = port_mem[rd_idx[g]];
    assign rd_stamp[g] = stamp_mem[rd_idx[g]];
  end

endmodule

// File: rtl/mlt_age.sv
module mlt_age #(
  parameter int TICK_UNIT = 4096
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [1:0]                    age_sel,
  output logic                          aging_on,
  output logic [mlt_pkg::STAMP_W-1:0]   epoch
);

  import mlt_pkg::*;

  localparam int LONG_CNT = TICK_UNIT * 16;
  localparam int CNT_W    = $clog2(LONG_CNT + 1);

  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [STAMP_W-1:0] epoch_q, epoch_d;
  logic [CNT_W-1:0]   last_cnt;
  logic               tick;

  always_comb begin
    case (age_sel_e'(age_sel))
      AGE_X1:  last_cnt = CNT_W'(TICK_UNIT - 1);
      AGE_X4:  last_cnt = CNT_W'(TICK_UNIT * 4 - 1);
      AGE_X16: last_cnt = CNT_W'(TICK_UNIT * 16 - 1);
      default: last_cnt = '0;
    endcase
  end

  always_comb begin
    tick    = 1'b0;
    cnt_d   = cnt_q;
    epoch_d = epoch_q;
    if (age_sel_e'(age_sel) == AGE_OFF) begin
      cnt_d = '0;
    end else if (cnt_q >= last_cnt) begin
      tick  = 1'b1;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
    if (tick) epoch_d = epoch_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      epoch_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      epoch_q <= epoch_d;
    end
  end

  assign aging_on = (age_sel_e'(age_sel) != AGE_OFF);
  assign epoch    = epoch_q;

endmodule

// File: rtl/mlt_scan.sv
module mlt_scan #(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall,
  output logic [IDX_W-1:0] idx
);

  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (!stall) idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign idx = idx_q;

endmodule

// File: rtl/mac_learn_table.sv
module mac_learn_table #(
  parameter int PORTS     = 2,
  parameter int IDX_W     = 10,
  parameter int TICK_UNIT = 4096,
  localparam int PORT_W   = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORTS-1:0]  learn_en,
  input  logic [1:0]        age_sel,
  input  logic              lk_req,
  input  logic [47:0]       lk_mac,
  output logic              lk_ack,
  output logic              lk_hit,
  output logic [PORT_W-1:0] lk_port,
  input  logic              up_req,
  input  logic [47:0]       up_mac,
  input  logic [PORT_W-1:0] up_port,
  input  logic              up_good
);

  import mlt_pkg::*;

  localparam int RD_LK   = 0;
  localparam int RD_UP   = 1;
  localparam int RD_SCAN = 2;
  localparam int RD_N    = 3;

  logic rst_sync_n;

  mlt_rst_sync u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  logic [IDX_W-1:0] lk_idx, up_idx, scan_idx;

  mlt_hash #(.IDX_W(IDX_W)) u_hash_lk (.mac(lk_mac), .idx(lk_idx));
  mlt_hash #(.IDX_W(IDX_W)) u_hash_up (.mac(up_mac), .idx(up_idx));

  logic               aging_on;
  logic [STAMP_W-1:0] epoch;

  mlt_age #(.TICK_UNIT(TICK_UNIT)) u_age (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .age_sel  (age_sel),
    .aging_on (aging_on),
    .epoch    (epoch)
  );

  logic                           upd_we;
  logic                           clr_en;
  logic [RD_N-1:0][IDX_W-1:0]     rd_idx;
  logic [RD_N-1:0]                rd_vld;
  logic [RD_N-1:0][MAC_W-1:0]     rd_mac;
  logic [RD_N-1:0][PORT_W-1:0]    rd_port;
  logic [RD_N-1:0][STAMP_W-1:0]   rd_stamp;

  mlt_scan #(.IDX_W(IDX_W)) u_scan (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .stall (upd_we),
    .idx   (scan_idx)
  );

  assign rd_idx[RD_LK]   = lk_idx;
  assign rd_idx[RD_UP]   = up_idx;
  assign rd_idx[RD_SCAN] = scan_idx;

  mlt_store #(.IDX_W(IDX_W), .PORT_W(PORT_W), .RD_PORTS(RD_N)) u_store (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_idx   (rd_idx),
    .rd_vld   (rd_vld),
    .rd_mac   (rd_mac),
    .rd_port  (rd_port),
    .rd_stamp (rd_stamp),
    .wr_en    (upd_we),
    .wr_idx   (up_idx),
    .wr_mac   (up_mac),
    .wr_port  (up_port),
    .wr_stamp (epoch),
    .clr_en   (clr_en),
    .clr_idx  (scan_idx)
  );

  // Learn decision for the frame that just ended.
  learn_act_e act;
  logic       learn_ok;
  logic       up_match;

  always_comb begin
    learn_ok = up_req && up_good && learn_en[up_port] && !up_mac[GROUP_BIT];
    up_match = rd_vld[RD_UP] && (rd_mac[RD_UP] == up_mac);
    if (!learn_ok)          act = ACT_NONE;
    else if (up_match)      act = ACT_REFRESH;
    else if (rd_vld[RD_UP]) act = ACT_REPLACE;
    else                    act = ACT_INSERT;
  end

  assign upd_we = (act != ACT_NONE);

  // Aging: delete the scanned slot once its stamp is far enough behind.
  logic [STAMP_W-1:0] age_diff;
  logic               stale;

  always_comb begin
    age_diff = epoch - rd_stamp[RD_SCAN];
    stale    = aging_on && rd_vld[RD_SCAN] && (age_diff >= STAMP_W'(EXPIRE_AGE));
  end

  assign clr_en = stale && !upd_we;

  // Lookup result register: reads the table before this cycle's write.
  logic              lk_ack_q, lk_ack_d;
  logic              lk_hit_q, lk_hit_d;
  logic [PORT_W-1:0] lk_port_q, lk_port_d;

  always_comb begin
    lk_ack_d  = lk_req;
    lk_hit_d  = lk_req && rd_vld[RD_LK] && (rd_mac[RD_LK] == lk_mac);
    lk_port_d = lk_hit_d ? rd_port[RD_LK] : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      lk_ack_q  <= 1'b0;
      lk_hit_q  <= 1'b0;
      lk_port_q <= '0;
    end else begin
      lk_ack_q  <= lk_ack_d;
      lk_hit_q  <= lk_hit_d;
      lk_port_q <= lk_port_d;
    end
  end

  assign lk_ack  = lk_ack_q;
  assign lk_hit  = lk_hit_q;
  assign lk_port = lk_port_q;

endmodule

// File: rtl/mlt_checker.sv
module mlt_checker #(
  parameter int PORTS  = 2,
  parameter int IDX_W  = 10,
  parameter int PORT_W = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PORTS-1:0]  learn_en,
  input logic [1:0]        age_sel,
  input logic              lk_req,
  input logic              lk_ack,
  input logic              lk_hit,
  input logic              up_req,
  input logic [47:0]       up_mac,
  input logic [PORT_W-1:0] up_port,
  input logic              up_good,
  input logic [1:0]        epoch,
  input logic              upd_we,
  input logic [IDX_W-1:0]  scan_idx
);

  // R2
  lk_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> lk_ack);

  // R2
  lk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> (!lk_ack && !lk_hit));

  // R4
  bad_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req && !up_good) |-> !upd_we);

  // R5
  port_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req && !learn_en[up_port]) |-> !upd_we);

  // R6
  group_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req && up_mac[40]) |-> !upd_we);

  // R9
  epoch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_sel == 2'd0) |=> $stable(epoch));

  // R9
  epoch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (epoch != $past(epoch)) |-> (epoch == 2'($past(epoch) + 2'd1)));

  // R11
  scan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_we |=> $stable(scan_idx));

  // R11
  scan_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_we |=> (scan_idx == IDX_W'($past(scan_idx) + 1'b1)));

endmodule

bind mac_learn_table mlt_checker #(
  .PORTS  (PORTS),
  .IDX_W  (IDX_W),
  .PORT_W (PORT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .learn_en (learn_en),
  .age_sel  (age_sel),
  .lk_req   (lk_req),
  .lk_ack   (lk_ack),
  .lk_hit   (lk_hit),
  .up_req   (up_req),
  .up_mac   (up_mac),
  .up_port  (up_port),
  .up_good  (up_good),
  .epoch    (epoch),
  .upd_we   (upd_we),
  .scan_idx (scan_idx)
);

// File: tb/mac_learn_table_tb.sv
module mac_learn_table_tb;

  localparam int CLK_P  = 10;
  localparam int TU     = 2048;
  localparam int IDX_W  = 10;
  localparam int DEPTH  = 1 << IDX_W;

  logic        clk;
  logic        rst_n;
  logic [1:0]  learn_en;
  logic [1:0]  age_sel;
  logic        lk_req;
  logic [47:0] lk_mac;
  logic        lk_ack;
  logic        lk_hit;
  logic [0:0]  lk_port;
  logic        up_req;
  logic [47:0] up_mac;
  logic [0:0]  up_port;
  logic        up_good;

  int n_chk = 0;
  int n_err = 0;

  mac_learn_table #(.PORTS(2), .IDX_W(IDX_W), .TICK_UNIT(TU)) u_dut (
    .clk(clk), .rst_n(rst_n), .learn_en(learn_en), .age_sel(age_sel),
    .lk_req(lk_req), .lk_mac(lk_mac), .lk_ack(lk_ack), .lk_hit(lk_hit),
    .lk_port(lk_port), .up_req(up_req), .up_mac(up_mac), .up_port(up_port),
    .up_good(up_good)
  );

  initial clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  // Reference slot index, written from R3.
  function automatic int slot_of(input logic [47:0] a);
    logic [31:0] r;
    r = 32'hFFFF_FFFF;
    for (int b = 47; b >= 0; b--) begin
      if (r[31] != a[b]) r = (r << 1) ^ 32'h04C1_1DB7;
      else               r = r << 1;
    end
    return int'(r[IDX_W-1:0]);
  endfunction

  // Reference table contents for the phases without aging.
  bit          m_v    [DEPTH];
  logic [47:0] m_mac  [DEPTH];
  logic        m_port [DEPTH];

  function automatic void mdl_learn(input logic [47:0] m, input logic p, input bit good);
    int ix;
    if (good && learn_en[p] && !m[40]) begin
      ix = slot_of(m);
      m_v[ix] = 1'b1;
      m_mac[ix] = m;
      m_port[ix] = p;
    end
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic learn(input logic [47:0] m, input logic p, input bit good);
    @(negedge clk);
    up_req = 1'b1; up_mac = m; up_port = p; up_good = good;
    mdl_learn(m, p, good);
    @(negedge clk);
    up_req = 1'b0; up_good = 1'b0;
  endtask

  task automatic look(input logic [47:0] m, output bit hit, output logic p, output bit ack);
    @(negedge clk);
    lk_req = 1'b1; lk_mac = m;
    @(negedge clk);
    hit = lk_hit; p = lk_port[0]; ack = lk_ack;
    lk_req = 1'b0;
  endtask

  task automatic look_model(input logic [47:0] m, input string tag);
    bit h, a; logic p; int ix; bit eh;
    look(m, h, p, a);
    ix = slot_of(m);
    eh = m_v[ix] && (m_mac[ix] == m);
    chk(a == 1'b1, {tag, " ack"}, a, 1);
    chk(h == eh, {tag, " hit"}, h, eh);
    if (eh) chk(p == m_port[ix], {tag, " port"}, p, m_port[ix]);
  endtask

  task automatic look_exp(input logic [47:0] m, input bit eh, input logic ep, input string tag);
    bit h, a; logic p;
    look(m, h, p, a);
    chk(h == eh, {tag, " hit"}, h, eh);
    if (eh) chk(p == ep, {tag, " port"}, p, ep);
  endtask

  function automatic logic [47:0] rnd_uc();
    logic [47:0] v;
    v = {$urandom, $urandom};
    v[40] = 1'b0;
    return v;
  endfunction

  logic [47:0] pool [16];

  initial begin
    #(CLK_P * 150000);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    bit h, a; logic p;
    logic [47:0] ma, mb, mc, md, mx;
    void'($urandom(32'd20240517));
    rst_n = 1'b0; learn_en = 2'b11; age_sel = 2'd0;
    lk_req = 1'b0; lk_mac = '0; up_req = 1'b0; up_mac = '0; up_port = 1'b0; up_good = 1'b0;
    for (int i = 0; i < DEPTH; i++) m_v[i] = 1'b0;
    for (int i = 0; i < 14; i++) pool[i] = rnd_uc();
    pool[14] = rnd_uc() | (48'd1 << 40);
    pool[15] = pool[0];
    for (int k = 1; k < (1 << 20); k++) begin
      if (slot_of(pool[0] ^ 48'(k)) == slot_of(pool[0])) begin
        pool[15] = pool[0] ^ 48'(k);
        break;
      end
    end

    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(3);
    // R1: outputs low after reset, table empty
    chk(lk_ack == 1'b0, "R1 ack after reset", lk_ack, 0);
    chk(lk_hit == 1'b0, "R1 hit after reset", lk_hit, 0);
    look(pool[0], h, p, a);
    chk(a == 1'b1, "R2 ack on request", a, 1);
    chk(h == 1'b0, "R1 empty table miss", h, 0);

    // R2, R3: basic learn then lookup
    learn(pool[0], 1'b1, 1'b1);
    look_exp(pool[0], 1'b1, 1'b1, "R2 learned entry");

    // R4: bad frame is not learned
    learn(pool[1], 1'b0, 1'b0);
    look_exp(pool[1], 1'b0, 1'b0, "R4 bad frame");

    // R5: disabled port neither inserts nor moves
    learn_en = 2'b01;
    learn(pool[2], 1'b1, 1'b1);
    look_exp(pool[2], 1'b0, 1'b0, "R5 port1 off insert");
    learn(pool[2], 1'b0, 1'b1);
    look_exp(pool[2], 1'b1, 1'b0, "R5 port0 on insert");
    learn_en = 2'b10;
    learn(pool[0], 1'b0, 1'b1);
    look_exp(pool[0], 1'b1, 1'b1, "R5 port0 off no move");
    learn_en = 2'b11;

    // R6: group source never learned
    learn(pool[14], 1'b0, 1'b1);
    look_exp(pool[14], 1'b0, 1'b0, "R6 group source");

    // R7: known address moves port
    learn(pool[0], 1'b0, 1'b1);
    look_exp(pool[0], 1'b1, 1'b0, "R7 station move");

    // R3: same-slot address replaces the old one
    chk(pool[15] != pool[0], "R3 collision partner found", pool[15], 0);
    learn(pool[15], 1'b1, 1'b1);
    look_exp(pool[15], 1'b1, 1'b1, "R3 new occupant");
    look_exp(pool[0], 1'b0, 1'b0, "R3 evicted occupant");

    // R8: lookup in the same cycle as the learn sees the old table
    mx = rnd_uc();
    @(negedge clk);
    up_req = 1'b1; up_mac = mx; up_port = 1'b1; up_good = 1'b1;
    lk_req = 1'b1; lk_mac = mx;
    mdl_learn(mx, 1'b1, 1'b1);
    @(negedge clk);
    chk(lk_hit == 1'b0, "R8 same cycle miss", lk_hit, 0);
    up_req = 1'b0; up_good = 1'b0;
    @(negedge clk);
    chk(lk_hit == 1'b1, "R8 next cycle hit", lk_hit, 1);
    lk_req = 1'b0;

    // Random mix against the reference table, aging off
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom % 8);
      if (r < 3)       look_model(pool[$urandom % 16], "R2 random lookup");
      else if (r < 6)  learn(pool[$urandom % 16], 1'($urandom % 2), ($urandom % 4) != 0);
      else if (r == 6) learn_en = 2'($urandom % 4);
      else             look_model(rnd_uc(), "R3 random unknown");
    end
    learn_en = 2'b11;

    // R10: aging off keeps entries
    mx = rnd_uc();
    learn(mx, 1'b0, 1'b1);
    wait_cyc(7000);
    look_exp(mx, 1'b1, 1'b0, "R10 aging off keeps");

    // R9, R10, R7: shortest epoch, refreshed versus idle entry
    age_sel = 2'd1;
    ma = rnd_uc(); mb = rnd_uc();
    learn(ma, 1'b0, 1'b1);
    learn(mb, 1'b1, 1'b1);
    for (int i = 0; i < 6; i++) begin
      wait_cyc(1000);
      if (i == 0) look_exp(mb, 1'b1, 1'b1, "R10 young entry kept");
      learn(ma, 1'b0, 1'b1);
    end
    look_exp(ma, 1'b1, 1'b0, "R7 refreshed entry kept");
    look_exp(mb, 1'b0, 1'b0, "R10 idle entry aged");

    // R9: longest epoch keeps entry past short-epoch lifetime
    age_sel = 2'd3;
    mc = rnd_uc();
    learn(mc, 1'b1, 1'b1);
    wait_cyc(6000);
    look_exp(mc, 1'b1, 1'b1, "R9 x16 epoch kept");

    // R9: middle epoch keeps, then removes
    age_sel = 2'd2;
    md = rnd_uc();
    learn(md, 1'b0, 1'b1);
    wait_cyc(6000);
    look_exp(md, 1'b1, 1'b0, "R9 x4 epoch kept");
    wait_cyc(13000);
    look_exp(md, 1'b0, 1'b0, "R10 x4 epoch aged");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule